// File: doc/BRIEF.md
# Two-Wire Register Bridge

This block is a slave on a two-wire serial bus. It lets an external host read and write a bank of thirty-two 16-bit registers that sit behind a simple parallel port. The host first sends a 7-bit device address and a direction bit. For a write it then sends one register-select byte and the data. For a read it sends the register-select byte, issues a repeated START with the read bit set, and clocks the data out. Every register access moves one 16-bit word as two bytes, most significant byte first. After each completed word, the register pointer advances to the next register, so a single transaction can stream through the bank.

Both bus lines are oversampled by the system clock. The data line is modelled as open drain: `sda_i` is the level seen on the wire, and `sda_oe` pulls the wire low when it is 1. The register port has no back-pressure. A write strobe is a one-cycle pulse that the bank must accept in that cycle. A read strobe is a one-cycle request, and `reg_rdata` is sampled at the clock edge that ends it. The read strobe lets the bank clear bits that latch or clear themselves once they are read.

Top module: `twr_bridge`

## Requirements
- R1: After reset, `sda_oe`, `reg_we` and `reg_re` are 0 and `reg_addr` is 0.
- R2: A device byte whose upper seven bits equal 1010110 is acknowledged: SDA is held low during the ninth clock. Bit 0 of that byte selects read (1) or write (0).
- R3: Any other device address is not acknowledged. The block then drives nothing and issues no strobe until the next START.
- R4: A register-select byte of the form 000yyyyy is acknowledged and sets `reg_addr` to yyyyy. A register-select byte with any of its upper three bits set is not acknowledged, and the rest of the transaction is ignored.
- R5: In a write, both data bytes are acknowledged. One clock after the ninth clock of the second byte ends, `reg_we` pulses for one cycle. During that pulse `reg_wdata` is {first byte, second byte} and `reg_addr` is the selected register.
- R6: After each completed word, write or read, `reg_addr` increases by one, wrapping from 31 to 0.
- R7: In a read, `reg_re` pulses for one cycle while `reg_addr` holds the current register. The word is then sent MSB first: the high byte, then the low byte.
- R8: If the host acknowledges the low byte, the next register is read. If it does not acknowledge it, reading stops and no further `reg_re` is issued.
- R9: A STOP at any point returns the block to idle with SDA released. A write that has received only one data byte produces no `reg_we`.
- R10: `reg_we` and `reg_re` each last exactly one cycle and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_addr | output | 5 | Current register number |
| reg_wdata | output | 16 | Write word, valid while `reg_we` is 1 |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 16 | Read word, sampled at the edge ending `reg_re` |
| reg_re | output | 1 | One-cycle read strobe |

## Verification
A wrong phase or bit-count state appears at the ports within one bus bit time. Possible symptoms are a missing or misplaced acknowledge, data shifted by one bit on the read line, or a strobe that fires after the wrong byte. A wrong register pointer appears on `reg_addr` during the next strobe, and the sweep of all thirty-two registers traps it, including the wrap from 31 to 0. An address-matching fault appears in the sweep over every possible device address within the first byte.

// File: rtl/twr_pkg.sv
package twr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_RADR, ST_WHI, ST_WLO, ST_RLOAD, ST_THI, ST_TLO
  } twr_state_e;
  localparam int BYTE_W = 8;
  localparam int ACK_SLOT = BYTE_W + 1;
endpackage

// File: rtl/twr_line_sync.sv
module twr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES:0] scl_pipe, sda_pipe;
  logic scl_s, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign scl_d = scl_pipe[STAGES];
  assign sda_s = sda_pipe[STAGES-1];
  assign sda_d = sda_pipe[STAGES];

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twr_ctrl.sv
module twr_ctrl
  import twr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1010110,
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_p,
  input  logic          stop_p,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  input  logic [DW-1:0] reg_rdata,
  output logic          reg_re
);
  localparam int HB = DW - BYTE_W;

  twr_state_e  state;
  logic [3:0]  bitcnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh, hi_q, lo_q;
  logic mack, bump, rx_phase, tx_phase, byte_ok;

  assign reg_re   = (state == ST_RLOAD);
  assign rx_phase = state inside {ST_DEV, ST_RADR, ST_WHI, ST_WLO};
  assign tx_phase = state inside {ST_THI, ST_TLO};

  always_comb begin
    case (state)
      ST_DEV:  byte_ok = (rx_sh[BYTE_W-1:1] == DEV_ADDR);
      ST_RADR: byte_ok = (rx_sh[BYTE_W-1:AW] == '0);
      default: byte_ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; bitcnt <= '0; rx_sh <= '0; tx_sh <= '0;
      hi_q <= '0; lo_q <= '0; mack <= 1'b0; bump <= 1'b0;
      sda_oe <= 1'b0; reg_addr <= '0; reg_wdata <= '0; reg_we <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      bump   <= 1'b0;
      if (bump) reg_addr <= reg_addr + 1'b1;
      if (start_p) begin
        state <= ST_DEV; bitcnt <= '0; sda_oe <= 1'b0;
      end else if (stop_p) begin
        state <= ST_IDLE; sda_oe <= 1'b0;
      end else if (state == ST_RLOAD) begin
        tx_sh  <= reg_rdata[DW-1:HB];
        lo_q   <= reg_rdata[BYTE_W-1:0];
        sda_oe <= ~reg_rdata[DW-1];
        bitcnt <= '0;
        state  <= ST_THI;
      end else if (state != ST_IDLE && scl_rise) begin
        if (bitcnt < 4'(BYTE_W)) rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
        else mack <= ~sda_s;
        bitcnt <= bitcnt + 1'b1;
      end else if (state != ST_IDLE && scl_fall) begin
        if (bitcnt == 4'(BYTE_W)) begin
          if (rx_phase) begin
            sda_oe <= byte_ok;
            if (!byte_ok) state <= ST_IDLE;
          end else begin
            sda_oe <= 1'b0;
          end
        end else if (bitcnt == 4'(ACK_SLOT)) begin
          bitcnt <= '0;
          sda_oe <= 1'b0;
          case (state)
            ST_DEV:  state <= rx_sh[0] ? ST_RLOAD : ST_RADR;
            ST_RADR: begin reg_addr <= rx_sh[AW-1:0]; state <= ST_WHI; end
            ST_WHI:  begin hi_q <= rx_sh; state <= ST_WLO; end
            ST_WLO: begin
              reg_wdata <= {hi_q, rx_sh};
              reg_we    <= 1'b1;
              bump      <= 1'b1;
              state     <= ST_WHI;
            end
            ST_THI: begin
              if (mack) begin
                tx_sh <= lo_q; sda_oe <= ~lo_q[BYTE_W-1]; state <= ST_TLO;
              end else state <= ST_IDLE;
            end
            ST_TLO: begin
              reg_addr <= reg_addr + 1'b1;
              state    <= mack ? ST_RLOAD : ST_IDLE;
            end
            default: state <= ST_IDLE;
          endcase
        end else if (bitcnt != '0 && tx_phase) begin
          sda_oe <= ~tx_sh[BYTE_W-2];
          tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  // R10: strobes are single-cycle and mutually exclusive
  a_r10_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  a_r10_re_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));
  // R6: pointer steps after a written word
  a_r6_we_step: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_addr == AW'($past(reg_addr) + 1'b1));
  // R9 / R3: nothing driven while idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);
  a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !sda_oe);
endmodule

// File: rtl/twr_bridge.sv
module twr_bridge #(
  parameter logic [6:0] DEV_ADDR = 7'b1010110,
  parameter int SYNC_STAGES = 2,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic [15:0]   reg_wdata,
  output logic          reg_we,
  input  logic [15:0]   reg_rdata,
  output logic          reg_re
);
  localparam int DW = 16;
  logic sda_s, scl_rise, scl_fall, start_p, stop_p;

  twr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p)
  );

  twr_ctrl #(.DEV_ADDR(DEV_ADDR), .AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .reg_re(reg_re)
  );
endmodule

// File: tb/sim_twr_bridge.sv
`timescale 1ns/1ps
module sim_twr_bridge;
  localparam int Q = 5;
  localparam logic [6:0] DEV = 7'b1010110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, host_sda = 1'b1;
  logic sda_oe, reg_we, reg_re;
  logic [4:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [15:0] mem [32];
  logic [15:0] expm [32];
  logic sda_line;
  int n_chk = 0, n_bad = 0, we_cnt = 0, re_cnt = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  assign sda_line  = host_sda & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  twr_bridge u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .reg_re(reg_re)
  );

  always @(posedge clk) begin
    if (reg_we) begin mem[reg_addr] <= reg_wdata; we_cnt <= we_cnt + 1; end
    if (reg_re) re_cnt <= re_cnt + 1;
    if (rst_n && reg_we && reg_re) begin
      n_bad <= n_bad + 1;
      $display("FAIL R10: both strobes high (we=%0b re=%0b expected not both)", reg_we, reg_re);
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; wt(Q); scl = 1'b1; wt(Q);
    host_sda = 1'b0; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; wt(Q); scl = 1'b1; wt(Q); host_sda = 1'b1; wt(4 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; wt(Q); scl = 1'b1; wt(2 * Q); scl = 1'b0; wt(Q);
    end
    host_sda = 1'b1; wt(Q); scl = 1'b1; wt(Q);
    acked = ~sda_line; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    host_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl = 1'b1; wt(Q); b[i] = sda_line; wt(Q); scl = 1'b0; wt(Q);
    end
    host_sda = ~give_ack; wt(Q); scl = 1'b1; wt(2 * Q); scl = 1'b0; wt(Q);
    host_sda = 1'b1;
  endtask

  function automatic logic [15:0] pat(input int r, input int salt);
    return 16'((r * 16'h1357 + salt) ^ 16'hA5C3);
  endfunction

  initial begin
    logic ak;
    logic [7:0] hb, lb;
    int wc0, rc0;
    logic [4:0] a0;
    for (int r = 0; r < 32; r++) begin mem[r] = '0; expm[r] = '0; end
    wt(4); rst_n = 1'b1; wt(4);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    chk(reg_we == 1'b0, "R1 reg_we", reg_we, 0);
    chk(reg_re == 1'b0, "R1 reg_re", reg_re, 0);
    chk(reg_addr == 5'd0, "R1 reg_addr", reg_addr, 0);

    // R2 R4 R5 R6: write every register, one transaction each
    for (int r = 0; r < 32; r++) begin
      wc0 = we_cnt;
      bus_start();
      send_byte({DEV, 1'b0}, ak); chk(ak, "R2 dev ack", ak, 1);
      send_byte(8'(r), ak); chk(ak, "R4 radr ack", ak, 1);
      send_byte(pat(r, 0) >> 8, ak); chk(ak, "R5 hi ack", ak, 1);
      send_byte(pat(r, 0) & 16'hFF, ak); chk(ak, "R5 lo ack", ak, 1);
      bus_stop();
      expm[r] = pat(r, 0);
      chk(mem[r] == expm[r], "R5 written word", mem[r], expm[r]);
      chk(we_cnt == wc0 + 1, "R5 one strobe", we_cnt - wc0, 1);
      chk(reg_addr == 5'(r + 1), "R6 pointer step", reg_addr, (r + 1) % 32);
      chk(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);
    end

    // R6 wrap: two words from 31
    bus_start();
    send_byte({DEV, 1'b0}, ak);
    send_byte(8'd31, ak);
    send_byte(pat(31, 7) >> 8, ak); send_byte(pat(31, 7) & 16'hFF, ak);
    send_byte(pat(0, 7) >> 8, ak);  send_byte(pat(0, 7) & 16'hFF, ak);
    bus_stop();
    expm[31] = pat(31, 7); expm[0] = pat(0, 7);
    chk(mem[31] == expm[31], "R6 burst first", mem[31], expm[31]);
    chk(mem[0] == expm[0], "R6 burst wrap", mem[0], expm[0]);
    chk(reg_addr == 5'd1, "R6 pointer after wrap", reg_addr, 1);

    // R7 R8: burst read all registers from 0
    rc0 = re_cnt;
    bus_start();
    send_byte({DEV, 1'b0}, ak);
    send_byte(8'd0, ak);
    bus_start();
    send_byte({DEV, 1'b1}, ak); chk(ak, "R2 read dev ack", ak, 1);
    for (int r = 0; r < 32; r++) begin
      recv_byte(1'b1, hb);
      recv_byte(r != 31, lb);
      chk({hb, lb} == expm[r], "R7 read word", {hb, lb}, expm[r]);
    end
    bus_stop();
    chk(re_cnt == rc0 + 32, "R8 strobes stop at nak", re_cnt - rc0, 32);
    chk(reg_addr == 5'd0, "R6 read pointer wrap", reg_addr, 0);

    // R4 bad register-select bytes
    for (int k = 1; k < 8; k++) begin
      wc0 = we_cnt; a0 = reg_addr;
      bus_start();
      send_byte({DEV, 1'b0}, ak);
      send_byte({3'(k), 5'd3}, ak); chk(!ak, "R4 bad radr nak", ak, 0);
      send_byte(8'h12, ak); chk(!ak, "R4 ignored data", ak, 0);
      send_byte(8'h34, ak);
      bus_stop();
      chk(we_cnt == wc0, "R4 no write", we_cnt - wc0, 0);
      chk(reg_addr == a0, "R4 pointer kept", reg_addr, a0);
    end

    // R9 partial write
    wc0 = we_cnt;
    bus_start();
    send_byte({DEV, 1'b0}, ak);
    send_byte(8'd5, ak);
    send_byte(8'hEE, ak);
    bus_stop();
    chk(we_cnt == wc0, "R9 half word no write", we_cnt - wc0, 0);
    chk(mem[5] == expm[5], "R9 register kept", mem[5], expm[5]);

    // R3 sweep every non-matching device address
    wc0 = we_cnt; rc0 = re_cnt;
    for (int a = 0; a < 128; a++) begin
      if (7'(a) != DEV) begin
        bus_start();
        send_byte({7'(a), a[0]}, ak); chk(!ak, "R3 foreign addr nak", ak, 0);
        send_byte(8'h00, ak); chk(!ak, "R3 silent after nak", ak, 0);
        bus_stop();
      end
    end
    chk(we_cnt == wc0, "R3 no write strobe", we_cnt - wc0, 0);
    chk(re_cnt == rc0, "R3 no read strobe", re_cnt - rc0, 0);

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule